// File: doc/BRIEF.md
# Paired Down-Counter PWM Generator

This block pairs two 16-bit down-counters to produce one pulse-width-modulated output. The period counter sets the repetition rate. Each time it passes zero it reloads itself from the period value and raises a one-cycle interrupt. The width counter is retriggered by that same terminal event: it loads the duty value, turns the output on at the next count tick, and turns it off when it underflows from zero. After underflow it rests at all-ones until the next retrigger.

Counting advances only on clock cycles where the count-enable strobe is high, so any prescaler sits outside the block. The start and stop triggers are single-cycle pulses that act on both counters together. The pin stage selects between the timer level and a software level, and it can invert the timer level. Both counter values are visible at the ports at all times.

The period is `period_val + 1` ticks. The output is active for `min(duty_val, period_val + 1)` ticks of each period.

Top module: `pwm_pair_timer`

## Requirements
- R1: While reset is asserted and right after it is released, `run_flag` is 0, both counters read FFFFh and the timer level is inactive. With `out_en`=1 and `out_invert`=0, `pwm_out` is 0.
- R2: A `start_trig` pulse sets `run_flag` and loads the period counter with `period_val` on the following clock edge. If `stop_trig` is high in the same cycle, stop wins.
- R3: While running, each tick decrements the period counter. A tick that finds it at 0000h reloads it from `period_val` and pulses `master_irq` high for one cycle. Consecutive pulses are therefore `period_val`+1 ticks apart.
- R4: On each period-counter terminal event the width counter loads `duty_val`. On the next tick the output goes active, provided the loaded value is nonzero.
- R5: The output goes inactive on the tick where the width counter underflows from 0000h to FFFFh. The width counter then stays at FFFFh until the next terminal event.
- R6: New values written to `period_val` and `duty_val` while running take effect at the next terminal-event reload.
- R7: A `stop_trig` pulse clears `run_flag`. Both counters and the output level then hold their values.
- R8: With `out_en`=0, `pwm_out` follows `out_sw_level` whatever the timer state.
- R9: With `out_invert`=1, the timer level drives `pwm_out` as active-low. The active level is `!out_invert`.
- R10: With `duty_val`=0, the output never goes active. With `duty_val` greater than `period_val`, it stays active continuously.
- R11: While `cnt_en` is 0, neither counter changes even though `run_flag` is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cnt_en | input | 1 | Count tick strobe |
| start_trig | input | 1 | Start pulse for both counters |
| stop_trig | input | 1 | Stop pulse for both counters |
| period_val | input | 16 | Period reload value |
| duty_val | input | 16 | Width reload value |
| out_en | input | 1 | 1 selects the timer level for the pin |
| out_sw_level | input | 1 | Pin level when `out_en` is 0 |
| out_invert | input | 1 | Active-low output when 1 |
| run_flag | output | 1 | Counters enabled |
| master_count | output | 16 | Period counter value |
| slave_count | output | 16 | Width counter value |
| master_irq | output | 1 | One-cycle terminal-event pulse |
| pwm_out | output | 1 | PWM pin |

## Verification
A corrupted period counter shows at once on `master_count`. Within one period it also shows as `master_irq` spacing that differs from `period_val`+1. A bad width counter or pending flag moves the rising edge of `pwm_out` away from the tick right after the interrupt, or changes the active count inside a period window. A width counter that fails to rest at FFFFh shows up as an extra output edge before the next interrupt. The bench therefore measures edges and active counts over whole periods, starting right after an interrupt.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;

    // Resolved trigger command for one clock cycle
    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_START = 2'd1,
        CMD_STOP  = 2'd2
    } trig_cmd_e;

    // Stop takes priority over start when both arrive together
    function automatic trig_cmd_e resolve_trig(input logic start_p, input logic stop_p);
        if (stop_p) begin
            return CMD_STOP;
        end
        if (start_p) begin
            return CMD_START;
        end
        return CMD_NONE;
    endfunction

endpackage

// File: rtl/pwm_trig_decode.sv
module pwm_trig_decode
    import pwm_pair_pkg::*;
(
    input  logic      start_i,
    input  logic      stop_i,
    output trig_cmd_e cmd_o
);

    always_comb begin
        cmd_o = resolve_trig(start_i, stop_i);
    end

endmodule

// File: rtl/pwm_master_chan.sv
module pwm_master_chan
    import pwm_pair_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  trig_cmd_e        cmd_i,
    input  logic [CNT_W-1:0] period_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             run_o,
    output logic             evt_o,
    output logic             irq_o
);

    localparam logic [CNT_W-1:0] ONES = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ZERO = {CNT_W{1'b0}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
        logic             irq;
    } mst_state_t;

    mst_state_t st_d, st_q;
    logic       evt_d;

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;
        evt_d    = (cmd_i == CMD_NONE) && st_q.run && tick_i && (st_q.cnt == ZERO);
        case (cmd_i)
            CMD_STOP: begin
                st_d.run = 1'b0;
            end
            CMD_START: begin
                st_d.run = 1'b1;
                st_d.cnt = period_i;
            end
            default: begin
                if (st_q.run && tick_i) begin
                    if (evt_d) begin
                        st_d.cnt = period_i;
                        st_d.irq = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt - 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{cnt: ONES, run: 1'b0, irq: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
    assign run_o = st_q.run;
    assign evt_o = evt_d;
    assign irq_o = st_q.irq;

    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_START) |=> (st_q.run && st_q.cnt == $past(period_i)));

    p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o |=> (irq_o && st_q.cnt == $past(period_i)));

    p_decrement_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_NONE && st_q.run && tick_i && st_q.cnt != ZERO)
        |=> (st_q.cnt == $past(st_q.cnt) - 1'b1) && !irq_o);

    p_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_STOP) |=> (!st_q.run && $stable(st_q.cnt)));

    p_freeze_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_NONE && !tick_i) |=> $stable(st_q.cnt));

endmodule

// File: rtl/pwm_slave_chan.sv
module pwm_slave_chan
    import pwm_pair_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             run_i,
    input  trig_cmd_e        cmd_i,
    input  logic             evt_i,
    input  logic [CNT_W-1:0] duty_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             act_o
);

    localparam logic [CNT_W-1:0] ONES = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] ZERO = {CNT_W{1'b0}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             pend;  // loaded, first tick not yet taken
        logic             act;   // timer level before polarity
    } slv_state_t;

    slv_state_t st_d, st_q;
    logic       step;

    always_comb begin
        st_d = st_q;
        step = (cmd_i == CMD_NONE) && run_i && tick_i;
        if (cmd_i == CMD_START) begin
            st_d.pend = 1'b0;
        end else if (step) begin
            if (st_q.pend) begin
                st_d.pend = 1'b0;
                if (st_q.cnt != ZERO) begin
                    st_d.act = 1'b1;
                    st_d.cnt = st_q.cnt - 1'b1;
                end else begin
                    st_d.cnt = ONES;
                end
            end else if (st_q.cnt == ZERO) begin
                st_d.act = 1'b0;
                st_d.cnt = ONES;
            end else if (st_q.cnt != ONES) begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
            if (evt_i) begin
                st_d.cnt  = duty_i;
                st_d.pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{cnt: ONES, pend: 1'b0, act: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o = st_q.cnt;
    assign act_o = st_q.act;

    p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        evt_i |=> (st_q.cnt == $past(duty_i) && st_q.pend));

    p_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && st_q.pend && st_q.cnt != ZERO) |=> act_o);

    p_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !st_q.pend && st_q.cnt == ZERO) |=> !act_o);

    p_park_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt == ONES && !st_q.pend && !evt_i) |=> (st_q.cnt == ONES));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i) |=> $stable(act_o));

endmodule

// File: rtl/pwm_pin_drive.sv
module pwm_pin_drive (
    input  logic act_i,
    input  logic oe_i,
    input  logic sw_level_i,
    input  logic invert_i,
    output logic pin_o
);

    always_comb begin
        if (oe_i) begin
            pin_o = act_i ^ invert_i;
        end else begin
            pin_o = sw_level_i;
        end
    end

endmodule

// File: rtl/pwm_pair_timer.sv
module pwm_pair_timer
    import pwm_pair_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             start_trig,
    input  logic             stop_trig,
    input  logic [CNT_W-1:0] period_val,
    input  logic [CNT_W-1:0] duty_val,
    input  logic             out_en,
    input  logic             out_sw_level,
    input  logic             out_invert,
    output logic             run_flag,
    output logic [CNT_W-1:0] master_count,
    output logic [CNT_W-1:0] slave_count,
    output logic             master_irq,
    output logic             pwm_out
);

    trig_cmd_e cmd;
    logic      mst_evt;
    logic      slv_act;

    pwm_trig_decode u_trig (
        .start_i (start_trig),
        .stop_i  (stop_trig),
        .cmd_o   (cmd)
    );

    pwm_master_chan #(.CNT_W(CNT_W)) u_master (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (cnt_en),
        .cmd_i    (cmd),
        .period_i (period_val),
        .cnt_o    (master_count),
        .run_o    (run_flag),
        .evt_o    (mst_evt),
        .irq_o    (master_irq)
    );

    pwm_slave_chan #(.CNT_W(CNT_W)) u_slave (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (cnt_en),
        .run_i  (run_flag),
        .cmd_i  (cmd),
        .evt_i  (mst_evt),
        .duty_i (duty_val),
        .cnt_o  (slave_count),
        .act_o  (slv_act)
    );

    pwm_pin_drive u_pin (
        .act_i      (slv_act),
        .oe_i       (out_en),
        .sw_level_i (out_sw_level),
        .invert_i   (out_invert),
        .pin_o      (pwm_out)
    );

    p_irq_needs_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
        master_irq |-> $past(run_flag));

endmodule

// File: tb/pwm_pair_timer_bench.sv
module pwm_pair_timer_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0;
    logic        start_trig = 1'b0;
    logic        stop_trig = 1'b0;
    logic [15:0] period_val = 16'd9;
    logic [15:0] duty_val = 16'd3;
    logic        out_en = 1'b1;
    logic        out_sw_level = 1'b0;
    logic        out_invert = 1'b0;
    logic        run_flag;
    logic [15:0] master_count;
    logic [15:0] slave_count;
    logic        master_irq;
    logic        pwm_out;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pwm_pair_timer u_pwm_pair_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .cnt_en       (cnt_en),
        .start_trig   (start_trig),
        .stop_trig    (stop_trig),
        .period_val   (period_val),
        .duty_val     (duty_val),
        .out_en       (out_en),
        .out_sw_level (out_sw_level),
        .out_invert   (out_invert),
        .run_flag     (run_flag),
        .master_count (master_count),
        .slave_count  (slave_count),
        .master_irq   (master_irq),
        .pwm_out      (pwm_out)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_irq();
        for (int i = 0; i < 70000; i++) begin
            @(negedge clk);
            if (master_irq) return;
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start_trig = 1'b1;
        @(negedge clk) start_trig = 1'b0;
    endtask

    task automatic pulse_stop();
        @(negedge clk) stop_trig = 1'b1;
        @(negedge clk) stop_trig = 1'b0;
    endtask

    // active-level cycles over n whole periods, starting right after an irq
    task automatic measure_active(input int n_per, output int cnt);
        cnt = 0;
        wait_irq();
        for (int i = 0; i < n_per * (int'(period_val) + 1); i++) begin
            @(negedge clk);
            if (pwm_out == !out_invert) cnt++;
        end
    endtask

    task automatic t_reset_r1();
        @(negedge clk);
        check("R1 run_flag in reset", run_flag, 0);
        check("R1 master_count in reset", master_count, 16'hFFFF);
        check("R1 slave_count in reset", slave_count, 16'hFFFF);
        check("R1 pwm_out in reset", pwm_out, 0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        check("R1 run_flag after reset", run_flag, 0);
        check("R1 master_count after reset", master_count, 16'hFFFF);
    endtask

    task automatic t_start_r2();
        cnt_en = 1'b1;
        pulse_start();
        check("R2 run_flag after start", run_flag, 1);
        check("R2 master loaded from period", master_count, 9);
        @(negedge clk);
        check("R3 master count readable while running", master_count, 8);
    endtask

    task automatic t_period_r3();
        int gap;
        wait_irq();
        gap = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            gap++;
            if (master_irq) break;
        end
        check("R3 irq spacing", gap, 10);
        @(negedge clk);
        check("R3 irq single cycle", master_irq, 0);
    endtask

    task automatic t_edges_r4_r5();
        wait_irq();
        check("R4 slave loaded with duty", slave_count, 3);
        @(negedge clk);
        check("R4 output active one tick after irq", pwm_out, 1);
        check("R4 slave counting", slave_count, 2);
        @(negedge clk);
        @(negedge clk);
        check("R5 still active at slave zero", pwm_out, 1);
        check("R5 slave reaches zero", slave_count, 0);
        @(negedge clk);
        check("R5 inactive after underflow", pwm_out, 0);
        check("R5 slave parks at FFFF", slave_count, 16'hFFFF);
        repeat (3) @(negedge clk);
        check("R5 slave still parked", slave_count, 16'hFFFF);
        check("R5 output stays inactive", pwm_out, 0);
    endtask

    task automatic t_window_r4();
        int c;
        measure_active(3, c);
        check("R4 active ticks over 3 periods", c, 9);
    endtask

    task automatic t_duty_limits_r10();
        int c;
        duty_val = 16'd0;
        measure_active(3, c);
        check("R10 duty zero never active", c, 0);
        duty_val = 16'd20;
        measure_active(3, c);
        check("R10 duty above period always active", c, 30);
        duty_val = 16'd10;
        measure_active(3, c);
        check("R10 duty equal period+1 always active", c, 30);
        duty_val = 16'd3;
        measure_active(2, c);
    endtask

    task automatic t_update_r6();
        int gap;
        int c;
        wait_irq();
        period_val = 16'd5;
        duty_val = 16'd2;
        wait_irq();
        gap = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            gap++;
            if (master_irq) break;
        end
        check("R6 new period spacing", gap, 6);
        measure_active(2, c);
        check("R6 new duty width", c, 4);
        wait_irq();
        period_val = 16'd9;
        duty_val = 16'd3;
        wait_irq();
    endtask

    task automatic t_invert_r9();
        int c;
        out_invert = 1'b1;
        measure_active(3, c);
        check("R9 inverted active-low ticks", c, 9);
        out_invert = 1'b0;
    endtask

    task automatic t_swlevel_r8();
        @(negedge clk) out_en = 1'b0;
        out_sw_level = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            check("R8 pin follows software level 1", pwm_out, 1);
        end
        out_sw_level = 1'b0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            check("R8 pin follows software level 0", pwm_out, 0);
        end
        out_en = 1'b1;
    endtask

    task automatic t_cnten_r11();
        int m;
        int s;
        @(negedge clk) cnt_en = 1'b0;
        @(negedge clk);
        m = master_count;
        s = slave_count;
        repeat (5) @(negedge clk);
        check("R11 master frozen without tick", master_count, m);
        check("R11 slave frozen without tick", slave_count, s);
        check("R11 still running", run_flag, 1);
        cnt_en = 1'b1;
        @(negedge clk);
        check("R11 counting resumes", master_count, (m == 0) ? 9 : m - 1);
    endtask

    task automatic t_stop_r7();
        int m;
        int s;
        wait_irq();
        @(negedge clk);
        pulse_stop();
        check("R7 run_flag cleared", run_flag, 0);
        m = master_count;
        s = slave_count;
        repeat (6) @(negedge clk);
        check("R7 master held", master_count, m);
        check("R7 slave held", slave_count, s);
        check("R7 output level held active", pwm_out, 1);
        check("R7 no irq while stopped", master_irq, 0);
        pulse_start();
        check("R2 restart reloads master", master_count, 9);
        check("R2 restart sets run_flag", run_flag, 1);
        @(negedge clk) start_trig = 1'b1;
        stop_trig = 1'b1;
        @(negedge clk) start_trig = 1'b0;
        stop_trig = 1'b0;
        check("R2 stop wins over start", run_flag, 0);
    endtask

    initial begin
        t_reset_r1();
        t_start_r2();
        t_period_r3();
        t_edges_r4_r5();
        t_window_r4();
        t_duty_limits_r10();
        t_update_r6();
        t_invert_r9();
        t_swlevel_r8();
        t_cnten_r11();
        t_stop_r7();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule